// File: doc/BRIEF.md
# LCD Shift Clock Generator

This block derives the shift clock that paces every transfer on an LCD data bus from the system clock. The clock period is the system period times an even ratio: one of 2, 4, 8, 16, 24 or 48. A three-bit select picks the ratio, and a reserved panel mode forces the slowest one. Every period starts with a one-cycle enable pulse. The level output is low for the first half of the period and high for the second half, so the duty cycle is 50% for each ratio. A change of select never cuts a period short: the period already running finishes at its old length, and the new ratio is used from the next boundary.

Alongside the divider, a line-budget check works out how many shift clocks one display line needs. That count depends on the panel type: an STN monochrome or grayscale panel moves eight pixels per clock, an STN color panel needs three subpixels per pixel, and a TFT panel moves one pixel per clock. The count is multiplied by the selected ratio and compared against the horizontal sync period, given in system clocks. When the transfer would not finish strictly inside that period, the block raises an overrun flag.

All pins are plain control and status levels. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `lcd_shift_clk_gen`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, the outputs after that edge are `sclk_en`=0, `sclk`=0 and `line_overrun`=0.
- R2: With `mode` not 11, `div_sel` codes 000, 001, 010, 011, 100 and 101 give a shift clock period of 2, 4, 8, 16, 24 and 48 system clocks.
- R3: `div_sel` codes 110 and 111 give a period of 48 system clocks.
- R4: `mode`=11 (reserved) gives a period of 48 system clocks whatever the value of `div_sel`.
- R5: In each period of N system clocks, `sclk` is 0 for the first N/2 cycles and 1 for the last N/2 cycles.
- R6: A change of `div_sel` or `mode` is taken at the next period boundary. The period that is running completes at its old length.
- R7: With `mode`=00 (STN monochrome/grayscale), a line needs ceil(`seg_size`/8) shift clocks.
- R8: With `mode`=01 (STN color), a line needs ceil(3·`seg_size`/8) shift clocks.
- R9: With `mode`=10 (TFT), a line needs `seg_size` shift clocks. Reserved `mode`=11 also counts `seg_size` clocks, at ratio 48.
- R10: `line_overrun` is 1 exactly when (clocks per line) × (requested ratio) ≥ `line_period`, using the inputs sampled at the previous clock edge. A `line_period` of 0 therefore always flags.
- R11: `sclk_en` is high for exactly one system cycle, the first cycle of each period. The first pulse comes in the first cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode | input | 2 | Panel mode: 00 STN mono, 01 STN color, 10 TFT, 11 reserved |
| div_sel | input | 3 | Divider ratio select |
| seg_size | input | SEG_W (12) | Segment size in pixels per line |
| line_period | input | LP_W (16) | Horizontal sync period in system clocks |
| sclk_en | output | 1 | One-cycle pulse at the start of each shift clock period |
| sclk | output | 1 | Shift clock level |
| line_overrun | output | 1 | Line transfer does not fit inside the sync period |

## Verification
`sclk_en` and `sclk` are decoded from the period counter, so they reflect the counter state set by the most recent clock edge. A new ratio first shows up in the cycle after the edge that closes the running period. `line_overrun` is registered, so it shows the inputs that were present one edge earlier. The bench keeps a cycle model that advances only at that edge, and it compares all three outputs at the following falling edge. This keeps each expected value on the edge where the design produces it.

// File: rtl/lcd_sclk_pkg.sv
package lcd_sclk_pkg;

  typedef enum logic [1:0] {
    PANEL_STN_MONO  = 2'b00,
    PANEL_STN_COLOR = 2'b01,
    PANEL_TFT       = 2'b10,
    PANEL_RSVD      = 2'b11
  } panel_mode_e;

  localparam int RATIO_W = 6;

  // Divider ratio in system clocks per shift clock period.
  function automatic logic [RATIO_W-1:0] ratio_of(panel_mode_e m, logic [2:0] sel);
    logic [RATIO_W-1:0] r;
    if (m == PANEL_RSVD) begin
      r = RATIO_W'(48);
    end else begin
      case (sel)
        3'd0:    r = RATIO_W'(2);
        3'd1:    r = RATIO_W'(4);
        3'd2:    r = RATIO_W'(8);
        3'd3:    r = RATIO_W'(16);
        3'd4:    r = RATIO_W'(24);
        default: r = RATIO_W'(48);
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/lcd_sclk_ratio.sv
module lcd_sclk_ratio
  import lcd_sclk_pkg::*;
(
  input  panel_mode_e          mode,
  input  logic [2:0]           div_sel,
  output logic [RATIO_W-1:0]   ratio
);

  always_comb begin
    ratio = ratio_of(mode, div_sel);
  end

endmodule

// File: rtl/lcd_sclk_div.sv
module lcd_sclk_div #(
  parameter int RATIO_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] req_ratio,
  output logic               period_start,
  output logic               sclk_lvl
);

  logic [RATIO_W-1:0] cnt_q;
  logic [RATIO_W-1:0] ratio_q;
  logic               last_cyc;

  assign last_cyc = (cnt_q == ratio_q - RATIO_W'(1));

  // A new ratio is loaded only when the running period closes.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= req_ratio;
    end else if (last_cyc) begin
      cnt_q   <= '0;
      ratio_q <= req_ratio;
    end else begin
      cnt_q   <= cnt_q + RATIO_W'(1);
    end
  end

  assign period_start = rst_n && (cnt_q == '0);
  assign sclk_lvl     = (cnt_q >= (ratio_q >> 1));

  // R6: ratio held until the boundary
  assert_ratio_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !last_cyc |=> $stable(ratio_q));

  // R5: counter stays inside the active period
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < ratio_q);

endmodule

// File: rtl/lcd_line_budget.sv
module lcd_line_budget
  import lcd_sclk_pkg::*;
#(
  parameter int SEG_W = 12,
  parameter int LP_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  panel_mode_e        mode,
  input  logic [SEG_W-1:0]   seg_size,
  input  logic [RATIO_W-1:0] ratio,
  input  logic [LP_W-1:0]    line_period,
  output logic               overrun
);

  localparam int SX_W   = SEG_W + 2;
  localparam int PROD_W = SX_W + RATIO_W;
  localparam int CMP_W  = (PROD_W > LP_W) ? PROD_W : LP_W;

  logic [SX_W-1:0]  seg_x;
  logic [SX_W-1:0]  cpl;
  logic [CMP_W-1:0] need;
  logic             overrun_q;

  assign seg_x = {2'b00, seg_size};

  // Shift clocks per line, rounded up.
  always_comb begin
    case (mode)
      PANEL_STN_MONO:  cpl = (seg_x + SX_W'(7)) >> 3;
      PANEL_STN_COLOR: cpl = (seg_x * SX_W'(3) + SX_W'(7)) >> 3;
      default:         cpl = seg_x;
    endcase
  end

  assign need = CMP_W'(cpl) * CMP_W'(ratio);

  always_ff @(posedge clk) begin
    if (!rst_n) overrun_q <= 1'b0;
    else        overrun_q <= (need >= CMP_W'(line_period));
  end

  assign overrun = overrun_q;

  // R10: an empty line period can never hold a transfer
  assert_zero_period_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (line_period == '0) |=> overrun);

endmodule

// File: rtl/lcd_shift_clk_gen.sv
module lcd_shift_clk_gen
  import lcd_sclk_pkg::*;
#(
  parameter int SEG_W = 12,
  parameter int LP_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [2:0]       div_sel,
  input  logic [SEG_W-1:0] seg_size,
  input  logic [LP_W-1:0]  line_period,
  output logic             sclk_en,
  output logic             sclk,
  output logic             line_overrun
);

  panel_mode_e        mode_e;
  logic [RATIO_W-1:0] req_ratio;

  assign mode_e = panel_mode_e'(mode);

  lcd_sclk_ratio u_ratio (
    .mode    (mode_e),
    .div_sel (div_sel),
    .ratio   (req_ratio)
  );

  lcd_sclk_div #(.RATIO_W(RATIO_W)) u_div (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ratio    (req_ratio),
    .period_start (sclk_en),
    .sclk_lvl     (sclk)
  );

  lcd_line_budget #(.SEG_W(SEG_W), .LP_W(LP_W)) u_budget (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode_e),
    .seg_size    (seg_size),
    .ratio       (req_ratio),
    .line_period (line_period),
    .overrun     (line_overrun)
  );

  // R11: every falling edge of the shift clock opens a new period
  assert_fall_at_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> sclk_en);

  // R5: the period starts in the low half
  assert_start_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_en |-> !sclk);

endmodule

// File: tb/tb_lcd_shift_clk_gen.sv
`timescale 1ns/1ps
module tb_lcd_shift_clk_gen;
  localparam int SEG_W = 12;
  localparam int LP_W  = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       mode = 2'd0;
  logic [2:0]       div_sel = 3'd0;
  logic [SEG_W-1:0] seg = '0;
  logic [LP_W-1:0]  lp = '0;
  logic             sclk_en, sclk, ovr;

  int    n_run = 0, n_fail = 0;
  int    m_cnt = 0, m_ratio = 2;
  bit    m_ovr = 0;
  string m_tag = "R2", m_otag = "R10";
  string r6_tag = "";
  bit    done = 0;

  always #2.5 clk = ~clk;

  lcd_shift_clk_gen #(.SEG_W(SEG_W), .LP_W(LP_W)) dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .div_sel(div_sel),
    .seg_size(seg), .line_period(lp),
    .sclk_en(sclk_en), .sclk(sclk), .line_overrun(ovr)
  );

  function automatic int f_ratio(int md, int ds);
    if (md == 3) return 48;
    case (ds)
      0: return 2;
      1: return 4;
      2: return 8;
      3: return 16;
      4: return 24;
      default: return 48;
    endcase
  endfunction

  function automatic int f_cpl(int md, int s);
    if (md == 0) return (s + 7) / 8;
    if (md == 1) return (3 * s + 7) / 8;
    return s;
  endfunction

  function automatic string f_rtag(int md, int ds);
    if (md == 3) return "R4";
    if (ds >= 6) return "R3";
    return "R2";
  endfunction

  function automatic string f_otag(int md);
    if (md == 0) return "R10/R7";
    if (md == 1) return "R10/R8";
    return "R10/R9";
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Inputs are set; advance the model across the next edge, then check.
  task automatic cycle();
    bit en_exp, sclk_exp;
    if (!rst_n) begin
      m_cnt = 0; m_ratio = f_ratio(mode, div_sel); m_ovr = 0;
      m_tag = "R1"; m_otag = "R1";
    end else begin
      m_ovr  = (f_cpl(mode, seg) * f_ratio(mode, div_sel)) >= int'(lp);
      m_otag = f_otag(mode);
      if (m_cnt == m_ratio - 1) begin
        m_cnt = 0;
        m_ratio = f_ratio(mode, div_sel);
        m_tag = (r6_tag != "") ? r6_tag : f_rtag(mode, div_sel);
      end else begin
        m_cnt++;
      end
    end
    @(posedge clk);
    @(negedge clk);
    en_exp   = rst_n && (m_cnt == 0);
    sclk_exp = (m_cnt >= m_ratio / 2);
    chk(sclk_en === en_exp, rst_n ? {"R11/", m_tag} : "R1", int'(sclk_en), int'(en_exp));
    chk(sclk === sclk_exp, rst_n ? "R5" : "R1", int'(sclk), int'(sclk_exp));
    chk(ovr === m_ovr, m_otag, int'(ovr), int'(m_ovr));
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic budget(int md, int ds, int s, int p);
    mode = 2'(md); div_sel = 3'(ds); seg = SEG_W'(s); lp = LP_W'(p);
    run(3);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    run(4);                 // R1 reset state
    rst_n = 1'b1;
    // R2 R3 R4 R5 R11: every mode and select
    for (int md = 0; md < 4; md++)
      for (int ds = 0; ds < 8; ds++) begin
        mode = 2'(md); div_sel = 3'(ds);
        run(110);
      end
    // R6: change select in the middle of a long period
    r6_tag = "R6";
    mode = 2'd0; div_sel = 3'd5;
    run(60);
    div_sel = 3'd0;
    run(60);
    div_sel = 3'd4;
    run(7);
    div_sel = 3'd1;
    run(60);
    r6_tag = "";
    // R7 R8 R9 R10 boundaries
    budget(0, 0, 64, 16);  budget(0, 0, 64, 17);
    budget(0, 0, 65, 18);  budget(0, 0, 65, 19);
    budget(1, 1, 8, 12);   budget(1, 1, 8, 13);
    budget(1, 1, 9, 16);   budget(1, 1, 9, 17);
    budget(2, 4, 5, 120);  budget(2, 4, 5, 121);
    budget(3, 0, 5, 240);  budget(3, 0, 5, 241);
    budget(2, 0, 0, 0);    budget(0, 5, 4095, 0);
    // Random mix
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 19) == 0) begin
        int md, ds, s, p;
        md = $urandom_range(0, 3); ds = $urandom_range(0, 7);
        s  = $urandom_range(0, 4095);
        p  = f_cpl(md, s) * f_ratio(md, ds) + $urandom_range(0, 2) - 1;
        if ($urandom_range(0, 3) == 0) p = $urandom_range(0, 65535);
        if (p < 0) p = 0;
        if (p > 65535) p = 65535;
        mode = 2'(md); div_sel = 3'(ds); seg = SEG_W'(s); lp = LP_W'(p);
      end
      rst_n = ($urandom_range(0, 299) != 0);
      cycle();
    end
    rst_n = 1'b1;
    run(5);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL R11 watchdog act=0 exp=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule